// File: doc/BRIEF.md
# Accumulator logic and compare unit

This unit performs the bitwise, complement, carry-control and compare operations of an 8-bit accumulator datapath. Each operation combines the current accumulator with one operand byte and produces a new accumulator value and a five-bit status word. Instruction decode, operand fetch and shifts happen elsewhere. The unit does not know whether the operand came from a register, a memory byte or an immediate field.

The accumulator and the status word are registered inside the unit. They change only on a clock edge where the execute strobe is high. A synchronous reset clears both registers. Each operation has a fixed rule for the auxiliary-carry flag. Compare writes only the status word. Complementing the accumulator leaves the status word unchanged.

Top module: `acc_logic_unit`

## Requirements
- R1: Op code 0 (bitwise AND) loads the accumulator with accumulator AND operand. Sign, zero and parity follow the new value, carry becomes 0 and auxiliary carry becomes 1.
- R2: Op code 1 (bitwise OR) loads the accumulator with accumulator OR operand. Sign, zero and parity follow the new value, and both carry and auxiliary carry become 0.
- R3: Op code 2 (bitwise XOR) loads the accumulator with accumulator XOR operand. Sign, zero and parity follow the new value, and both carry and auxiliary carry become 0.
- R4: The status word is laid out as bit 4 sign, bit 3 zero, bit 2 auxiliary carry, bit 1 parity and bit 0 carry. Sign is bit 7 of the value. Zero is 1 when the value is 0x00. Parity is 1 when the value holds an even number of ones.
- R5: Op code 3 inverts every accumulator bit (0xAB becomes 0x54) and leaves the status word unchanged.
- R6: Op code 4 inverts the carry bit only. The accumulator and the other four status bits stay unchanged.
- R7: Op code 5 sets the carry bit to 1. The accumulator and the other four status bits stay unchanged.
- R8: Op code 6 (compare) never writes the accumulator. Carry becomes 1 exactly when the accumulator is below the operand as unsigned numbers. Zero becomes 1 exactly when the two are equal.
- R9: For compare, sign and parity follow the low byte of accumulator minus operand. Auxiliary carry is 1 exactly when the accumulator's low nibble is below the operand's low nibble. For example, 0x10 against 0x30 gives carry 1, zero 0, sign 1, parity 0 and auxiliary carry 0.
- R10: With the execute strobe low, or with op code 7, neither the accumulator nor the status word changes.
- R11: A synchronous reset clears the accumulator and the status word to zero and takes priority over the execute strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| exec | input | 1 | Execute strobe; registers update on the edges where it is high |
| op | input | 3 | Operation code, see requirements |
| operand | input | 8 | Operand byte from register, memory or immediate |
| acc_q | output | 8 | Registered accumulator |
| flags_q | output | 5 | Registered status word {sign, zero, aux carry, parity, carry} |

## Verification
The accumulator has no load path, so the hardest part is reaching an arbitrary accumulator value together with a chosen carry before the operation under test. The stimulus first ANDs with zero to clear the accumulator. It then ORs in the wanted value, which also gives a known status word, and optionally sets the carry. Only after that does it apply the operation under test. This prelude runs for every accumulator value. Each value meets several operand bytes, including itself, its neighbour and the nibble boundaries, so that the equal, below and nibble-borrow cases of compare all occur.

// File: rtl/acc_lu_pkg.sv
package acc_lu_pkg;

   localparam int FLAG_W = 5;

   // status word bit positions
   localparam int FB_CY   = 0;
   localparam int FB_PAR  = 1;
   localparam int FB_AUX  = 2;
   localparam int FB_ZERO = 3;
   localparam int FB_SIGN = 4;

   typedef enum logic [2:0] {
      LU_AND     = 3'd0,
      LU_OR      = 3'd1,
      LU_XOR     = 3'd2,
      LU_CPL_ACC = 3'd3,
      LU_CPL_CY  = 3'd4,
      LU_SET_CY  = 3'd5,
      LU_CMP     = 3'd6,
      LU_HOLD    = 3'd7
   } lu_op_e;

   typedef struct packed {
      logic sign;
      logic zero;
      logic aux;
      logic par;
      logic cy;
   } lu_flags_t;

endpackage

// File: rtl/lu_bitwise.sv
module lu_bitwise
   import acc_lu_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  lu_op_e            sel,
   output logic [DATA_W-1:0] res
);

   logic use_and;
   logic use_or;

   assign use_and = (sel == LU_AND);
   assign use_or  = (sel == LU_OR);

   // one slice per bit; XOR is the fallback for every other code
   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      assign res[i] = use_and ? (a[i] & b[i]) :
                      use_or  ? (a[i] | b[i]) :
                                (a[i] ^ b[i]);
   end

endmodule

// File: rtl/lu_compare.sv
module lu_compare #(
   parameter int DATA_W   = 8,
   parameter int SUB_IMPL = 0,  // 0: add inverted operand plus one, 1: direct subtract
   parameter int AUX_POS  = 4   // bit position whose incoming borrow is reported
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic [DATA_W-1:0] diff,
   output logic              borrow,
   output logic              nib_borrow
);

   if (SUB_IMPL == 0) begin : g_add_form
      logic [DATA_W:0] sum;
      logic [DATA_W-1:0] b_inv;
      assign b_inv  = ~b;
      assign sum    = {1'b0, a} + {1'b0, b_inv} + {{DATA_W{1'b0}}, 1'b1};
      assign diff   = sum[DATA_W-1:0];
      assign borrow = ~sum[DATA_W];
      // carry into AUX_POS recovered from the sum bit and its two inputs
      assign nib_borrow = ~(sum[AUX_POS] ^ a[AUX_POS] ^ b_inv[AUX_POS]);
   end else begin : g_sub_form
      logic [DATA_W:0] dwide;
      assign dwide  = {1'b0, a} - {1'b0, b};
      assign diff   = dwide[DATA_W-1:0];
      assign borrow = dwide[DATA_W];
      assign nib_borrow = dwide[AUX_POS] ^ a[AUX_POS] ^ b[AUX_POS];
   end

endmodule

// File: rtl/lu_status.sv
module lu_status #(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] value,
   output logic              sign,
   output logic              zero,
   output logic              even_par
);

   logic [DATA_W-1:0] par_chain;

   // ripple parity chain, one stage per bit
   for (genvar i = 0; i < DATA_W; i++) begin : g_par
      if (i == 0) begin : g_first
         assign par_chain[i] = value[i];
      end else begin : g_next
         assign par_chain[i] = par_chain[i-1] ^ value[i];
      end
   end

   assign sign     = value[DATA_W-1];
   assign zero     = (value == '0);
   assign even_par = ~par_chain[DATA_W-1];

endmodule

// File: rtl/acc_logic_unit.sv
module acc_logic_unit
   import acc_lu_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int SUB_IMPL = 0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              exec,
   input  logic [2:0]        op,
   input  logic [DATA_W-1:0] operand,
   output logic [DATA_W-1:0] acc_q,
   output logic [4:0]        flags_q
);

   localparam int AUX_POS = DATA_W / 2;

   if (DATA_W < 8 || (DATA_W % 2) != 0) begin : g_bad_width
      $error("acc_logic_unit: DATA_W must be even and at least 8");
   end
   if (SUB_IMPL != 0 && SUB_IMPL != 1) begin : g_bad_impl
      $error("acc_logic_unit: SUB_IMPL must be 0 or 1");
   end

   lu_op_e            op_e;
   logic [DATA_W-1:0] logic_res;
   logic [DATA_W-1:0] cmp_diff;
   logic              cmp_borrow;
   logic              cmp_nib_borrow;
   logic [DATA_W-1:0] stat_val;
   logic              st_sign, st_zero, st_par;
   lu_flags_t         cur_f, nxt_f;
   logic [DATA_W-1:0] nxt_acc;

   assign op_e  = lu_op_e'(op);
   assign cur_f = lu_flags_t'(flags_q);

   lu_bitwise #(.DATA_W(DATA_W)) i_bitwise (
      .a   (acc_q),
      .b   (operand),
      .sel (op_e),
      .res (logic_res)
   );

   lu_compare #(.DATA_W(DATA_W), .SUB_IMPL(SUB_IMPL), .AUX_POS(AUX_POS)) i_compare (
      .a          (acc_q),
      .b          (operand),
      .diff       (cmp_diff),
      .borrow     (cmp_borrow),
      .nib_borrow (cmp_nib_borrow)
   );

   assign stat_val = (op_e == LU_CMP) ? cmp_diff : logic_res;

   lu_status #(.DATA_W(DATA_W)) i_status (
      .value    (stat_val),
      .sign     (st_sign),
      .zero     (st_zero),
      .even_par (st_par)
   );

   always_comb begin
      nxt_acc = acc_q;
      nxt_f   = cur_f;
      unique case (op_e)
         LU_AND: begin
            nxt_acc = logic_res;
            nxt_f   = '{sign: st_sign, zero: st_zero, aux: 1'b1, par: st_par, cy: 1'b0};
         end
         LU_OR, LU_XOR: begin
            nxt_acc = logic_res;
            nxt_f   = '{sign: st_sign, zero: st_zero, aux: 1'b0, par: st_par, cy: 1'b0};
         end
         LU_CPL_ACC: nxt_acc  = ~acc_q;
         LU_CPL_CY:  nxt_f.cy = ~cur_f.cy;
         LU_SET_CY:  nxt_f.cy = 1'b1;
         LU_CMP: begin
            nxt_f = '{sign: st_sign, zero: st_zero, aux: cmp_nib_borrow,
                      par: st_par, cy: cmp_borrow};
         end
         LU_HOLD: ;
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         acc_q   <= '0;
         flags_q <= '0;
      end else if (exec) begin
         acc_q   <= nxt_acc;
         flags_q <= nxt_f;
      end
   end

endmodule

// File: rtl/lu_checker.sv
module lu_checker
   import acc_lu_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst,
   input logic              exec,
   input logic [2:0]        op,
   input logic [DATA_W-1:0] operand,
   input logic [DATA_W-1:0] acc_q,
   input logic [4:0]        flags_q
);

   AST_AND_FLAG_RULE: assert property (@(posedge clk) disable iff (rst)
      (exec && op == LU_AND) |=> (flags_q[FB_AUX] && !flags_q[FB_CY])); // R1

   AST_OR_FLAG_RULE: assert property (@(posedge clk) disable iff (rst)
      (exec && op == LU_OR) |=> (!flags_q[FB_AUX] && !flags_q[FB_CY])); // R2

   AST_XOR_FLAG_RULE: assert property (@(posedge clk) disable iff (rst)
      (exec && op == LU_XOR) |=> (!flags_q[FB_AUX] && !flags_q[FB_CY])); // R3

   AST_ZERO_MATCH: assert property (@(posedge clk) disable iff (rst)
      (exec && (op == LU_AND || op == LU_OR || op == LU_XOR))
      |=> (flags_q[FB_ZERO] == (acc_q == '0))); // R4

   AST_CPL_ACC: assert property (@(posedge clk) disable iff (rst)
      (exec && op == LU_CPL_ACC) |=> (acc_q == ~$past(acc_q) && $stable(flags_q))); // R5

   AST_CPL_CY: assert property (@(posedge clk) disable iff (rst)
      (exec && op == LU_CPL_CY)
      |=> (flags_q[FB_CY] != $past(flags_q[FB_CY]) && $stable(flags_q[4:1])
           && $stable(acc_q))); // R6

   AST_SET_CY: assert property (@(posedge clk) disable iff (rst)
      (exec && op == LU_SET_CY)
      |=> (flags_q[FB_CY] && $stable(flags_q[4:1]) && $stable(acc_q))); // R7

   AST_CMP_ORDER: assert property (@(posedge clk) disable iff (rst)
      (exec && op == LU_CMP)
      |=> ($stable(acc_q) && flags_q[FB_CY] == ($past(acc_q) < $past(operand))
           && flags_q[FB_ZERO] == ($past(acc_q) == $past(operand)))); // R8

   AST_CMP_NIBBLE: assert property (@(posedge clk) disable iff (rst)
      (exec && op == LU_CMP)
      |=> (flags_q[FB_AUX] == ($past(acc_q[3:0]) < $past(operand[3:0])))); // R9

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
      (!exec || op == LU_HOLD) |=> ($stable(acc_q) && $stable(flags_q))); // R10

endmodule

bind acc_logic_unit lu_checker #(.DATA_W(DATA_W)) i_lu_checker (
   .clk     (clk),
   .rst     (rst),
   .exec    (exec),
   .op      (op),
   .operand (operand),
   .acc_q   (acc_q),
   .flags_q (flags_q)
);

// File: tb/test_acc_logic_unit.sv
`timescale 1ns/1ps
module test_acc_logic_unit;

   logic       clk = 1'b0;
   logic       rst;
   logic       exec;
   logic [2:0] op;
   logic [7:0] operand;
   logic [7:0] acc_q;
   logic [4:0] flags_q;

   int errors = 0;
   int checks = 0;

   always #4 clk = ~clk;

   acc_logic_unit i_acc_logic_unit (
      .clk(clk), .rst(rst), .exec(exec), .op(op),
      .operand(operand), .acc_q(acc_q), .flags_q(flags_q)
   );

   function automatic logic even_ones(input logic [7:0] v);
      int n = 0;
      for (int i = 0; i < 8; i++) n += int'(v[i]);
      return (n % 2) == 0;
   endfunction

   // status word from a value: {sign, zero, aux, par, cy}
   function automatic logic [4:0] mk_flags(input logic [7:0] v, input logic aux, input logic cy);
      return {v[7], (v == 8'h00), aux, even_ones(v), cy};
   endfunction

   task automatic check(input string req, input logic [7:0] exp_acc, input logic [4:0] exp_f);
      checks++;
      if (acc_q !== exp_acc || flags_q !== exp_f) begin
         errors++;
         $display("FAIL %s: acc=%h flags=%b expected acc=%h flags=%b",
                  req, acc_q, flags_q, exp_acc, exp_f);
      end
   endtask

   // drive at a falling edge, registers load at the rising edge, sample at the next falling edge
   task automatic step(input logic e, input logic [2:0] o, input logic [7:0] b);
      exec = e; op = o; operand = b;
      @(negedge clk);
   endtask

   task automatic model(input logic [2:0] o, input logic [7:0] a, input logic [7:0] b,
                        input logic [4:0] f, output logic [7:0] ea, output logic [4:0] ef,
                        output string req);
      logic [7:0] d;
      ea = a; ef = f;
      case (o)
         3'd0: begin ea = a & b; ef = mk_flags(ea, 1'b1, 1'b0); req = "R1"; end
         3'd1: begin ea = a | b; ef = mk_flags(ea, 1'b0, 1'b0); req = "R2"; end
         3'd2: begin ea = a ^ b; ef = mk_flags(ea, 1'b0, 1'b0); req = "R3"; end
         3'd3: begin ea = 8'hFF - a; req = "R5"; end
         3'd4: begin ef[0] = ~f[0]; req = "R6"; end
         3'd5: begin ef[0] = 1'b1; req = "R7"; end
         3'd6: begin
            d  = 8'((int'(a) - int'(b) + 256) % 256);
            ef = mk_flags(d, int'(a % 16) < int'(b % 16), int'(a) < int'(b));
            req = "R8/R9";
         end
         default: req = "R10";
      endcase
   endtask

   initial begin
      logic [7:0] bl [8];
      logic [7:0] ea;
      logic [4:0] ef, pre;
      string      req;
      rst = 1'b1; exec = 1'b0; op = 3'd0; operand = 8'h00;
      @(negedge clk); @(negedge clk);
      check("R11 reset", 8'h00, 5'b00000);
      // reset overrides an execute strobe (OR 0xFF would otherwise load)
      step(1'b1, 3'd1, 8'hFF);
      check("R11 priority", 8'h00, 5'b00000);
      rst = 1'b0;

      // fixed example: 0x10 compared with 0x30 -> S=1 Z=0 AC=0 P=0 CY=1
      step(1'b1, 3'd1, 8'h10);
      step(1'b1, 3'd6, 8'h30);
      check("R9 example", 8'h10, 5'b10001);
      // complement example 0xAB -> 0x54, flags from the OR load untouched
      step(1'b1, 3'd0, 8'h00);
      step(1'b1, 3'd1, 8'hAB);
      step(1'b1, 3'd3, 8'h00);
      check("R5 example", 8'h54, mk_flags(8'hAB, 1'b0, 1'b0));

      for (int a = 0; a < 256; a++) begin
         bl[0] = 8'h00; bl[1] = 8'hFF; bl[2] = 8'h0F; bl[3] = 8'hF0;
         bl[4] = 8'h80; bl[5] = 8'(a); bl[6] = 8'(a) ^ 8'h01; bl[7] = 8'((a * 37 + 11) % 256);
         for (int o = 0; o < 8; o++) begin
            for (int k = 0; k < 8; k++) begin
               logic cy = 1'((a + k + o) % 2);
               step(1'b1, 3'd0, 8'h00);            // clear accumulator
               step(1'b1, 3'd1, 8'(a));            // load value through OR
               if (cy) step(1'b1, 3'd5, 8'h00);    // optional carry
               pre = mk_flags(8'(a), 1'b0, cy);
               check("R2/R4 setup", 8'(a), pre);
               step(1'b1, 3'(o), bl[k]);
               model(3'(o), 8'(a), bl[k], pre, ea, ef, req);
               check(req, ea, ef);
               // strobe low with a different code: nothing may change
               step(1'b0, 3'((o + 3) % 8), ~bl[k]);
               check("R10 idle", ea, ef);
            end
         end
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule